// File: doc/BRIEF.md
# Four-Lane Link Test Pattern Generator

This block produces the per-lane symbol words for a four-lane serial link encoder. Every clock it emits one 32-bit word per lane, and bit 0 of each word is the first bit on the wire. A small register write port sets a global operating mode. In active mode the enabled lanes carry the caller's payload. Two training modes drive a fixed training sequence on every enabled lane. In test mode each lane picks its own source, and the choices are:

- a PRBS generator with one of six polynomial orders;
- a 264-bit user pattern that repeats without a gap;
- a square wave of programmable width;
- either training sequence.

Register map, 5-bit word address:

| Address | Contents |
|---|---|
| 0 | Control. Mode in bits 1:0, where 0 is active, 1 is training 1, 2 is training 2 and 3 is test. Lane-count code in bits 3:2. |
| 1 | One byte per lane. Lane i uses bits 8i+7:8i. Its source select is in bits 8i+2:8i and its PRBS order code in bits 8i+6:8i+4. |
| 2 | Square-wave width in bits 7:0. |
| 16 to 26 | The user pattern, 24 bits per register. |

Writes to any other address do nothing. A register write that is presented before a rising edge is stored at that edge. The next rising edge then produces the first output word that uses it.

Top module: `lpg_top`

## Requirements
- R1: While reset is asserted every lane word is zero. After reset the block is in active mode with only lane 0 enabled.
- R2: In active mode (mode 0) each enabled lane outputs the `act_data` slice it sampled at the previous rising edge.
- R3: Training 1 means mode 1, or test mode with select code 3. Its word is 32'h5555_5555, so the bits alternate starting with a 1.
- R4: Training 2 means mode 2, or test mode with select code 4. It is the order-11 PRBS stream, restarted from the all-ones seed whenever training 2 becomes the lane's source.
- R5: Select code 0 gives a PRBS stream. Order codes 0 to 5 select x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Each output bit is the XOR of the two tapped state bits and is shifted into the state. The state is seeded with all ones whenever the lane's source or order code changes. The stream runs on across words.
- R6: Select code 1 sends the 264-bit user pattern. Pattern byte k is held in register 16+k/3, bits 8(k mod 3)+7 down to 8(k mod 3). The pattern starts at bit 0 of byte 0 when the code is selected and wraps seamlessly after bit 263.
- R7: Select code 2 sends a square wave: `width` ones, then `width` zeros, repeating and continuous across words, starting with ones when selected. A width of 0 gives all zeros.
- R8: Lane i is enabled when i is not greater than the lane-count code, so code 0 enables one lane, 1 enables two, 2 enables three and 3 enables four. Disabled lanes output zeros.
- R9: In test mode each lane's source is independent of the others. Select codes 5 to 7 give zeros, and order codes 6 and 7 act as order code 0.
- R10: A write to an address outside 0, 1, 2 and 16 to 26 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| act_data | input | 128 | Active-mode payload; lane i in bits 32i+31:32i |
| lane_word | output | 128 | Output words; lane i in bits 32i+31:32i |

## Verification
Every result has a latency of one register stage. Payload sampled at edge k is on `lane_word` after edge k. A register write captured at edge k first affects the word launched at edge k+1, and that word is also the first one taken from a fresh seed, pattern start or square phase. The bench mirrors this ordering in its reference model. On each rising edge the model first computes the expected words from its shadow configuration and only then applies the write seen at that edge. It compares all four lanes at the following falling edge, so every comparison sees settled outputs one stage after its cause.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int PRBS_MAX = 31;

    typedef enum logic [2:0] {
        K_ZERO, K_DATA, K_PRBS, K_CUST, K_SQUARE, K_TRAIN1, K_TRAIN2
    } lane_kind_e;

    localparam logic [1:0] MODE_ACTIVE = 2'd0;
    localparam logic [1:0] MODE_TRAIN1 = 2'd1;
    localparam logic [1:0] MODE_TRAIN2 = 2'd2;

    localparam logic [2:0] SEL_PRBS   = 3'd0;
    localparam logic [2:0] SEL_CUSTOM = 3'd1;
    localparam logic [2:0] SEL_SQUARE = 3'd2;
    localparam logic [2:0] SEL_TRAIN1 = 3'd3;
    localparam logic [2:0] SEL_TRAIN2 = 3'd4;

    localparam logic [2:0] ORDER_TRAIN2 = 3'd2;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_LANES = 1;
    localparam int ADDR_SQW   = 2;
    localparam int ADDR_CUST0 = 16;

    // returns {index of highest tap, index of second tap}
    function automatic logic [9:0] prbs_taps(input logic [2:0] code);
        case (code)
            3'd1:    prbs_taps = {5'd8,  5'd4};
            3'd2:    prbs_taps = {5'd10, 5'd8};
            3'd3:    prbs_taps = {5'd14, 5'd13};
            3'd4:    prbs_taps = {5'd22, 5'd17};
            3'd5:    prbs_taps = {5'd30, 5'd27};
            default: prbs_taps = {5'd6,  5'd5};
        endcase
    endfunction

endpackage

// File: rtl/lpg_cfg.sv
module lpg_cfg #(
    parameter int LANES     = 4,
    parameter int CUST_REGS = 11,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [1:0]                    mode,
    output logic [$clog2(LANES)-1:0]      lane_code,
    output logic [LANES-1:0][2:0]         sel,
    output logic [LANES-1:0][2:0]         order,
    output logic [7:0]                    sq_width,
    output logic [CUST_REGS*24-1:0]       custom
);
    import lpg_pkg::*;

    localparam int CODE_W = $clog2(LANES);

    typedef struct packed {
        logic [1:0]                  mode;
        logic [CODE_W-1:0]           code;
        logic [LANES-1:0][2:0]       sel;
        logic [LANES-1:0][2:0]       order;
        logic [7:0]                  sq_w;
        logic [CUST_REGS-1:0][23:0]  cust;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                cfg_d.mode = wdata[1:0];
                cfg_d.code = wdata[2 +: CODE_W];
            end
            if (addr == ADDR_W'(ADDR_LANES)) begin
                for (int i = 0; i < LANES; i++) begin
                    cfg_d.sel[i]   = wdata[8*i +: 3];
                    cfg_d.order[i] = wdata[8*i+4 +: 3];
                end
            end
            if (addr == ADDR_W'(ADDR_SQW)) begin
                cfg_d.sq_w = wdata[7:0];
            end
            for (int r = 0; r < CUST_REGS; r++) begin
                if (addr == ADDR_W'(ADDR_CUST0 + r)) begin
                    cfg_d.cust[r] = wdata[23:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign mode      = cfg_q.mode;
    assign lane_code = cfg_q.code;
    assign sel       = cfg_q.sel;
    assign order     = cfg_q.order;
    assign sq_width  = cfg_q.sq_w;
    assign custom    = cfg_q.cust;

endmodule

// File: rtl/lpg_lane.sv
module lpg_lane
    import lpg_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int CUST_BYTES = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lane_kind_e              kind,
    input  logic [2:0]              order,
    input  logic [7:0]              sq_width,
    input  logic [CUST_BYTES*8-1:0] custom,
    input  logic [WORD_W-1:0]       data_in,
    output logic [WORD_W-1:0]       word
);
    localparam int BPW   = WORD_W / 8;
    localparam int PTR_W = $clog2(CUST_BYTES + 1);
    localparam logic [WORD_W-1:0] TRAIN1_WORD = {(WORD_W/2){2'b01}};

    typedef struct packed {
        lane_kind_e           kind_prev;
        logic [2:0]           order_prev;
        logic [PRBS_MAX-1:0]  prbs;
        logic [PTR_W-1:0]     ptr;
        logic [7:0]           sq_cnt;
        logic                 sq_lvl;
        logic [WORD_W-1:0]    word;
    } lane_state_t;

    localparam lane_state_t LANE_RST = '{K_ZERO, 3'd0, '1, '0, 8'd0, 1'b0, '0};

    lane_state_t st_d, st_q;

    logic                restart;
    logic [2:0]          eff_order;
    logic [9:0]          taps;
    logic [4:0]          tap_hi, tap_lo;
    logic [PRBS_MAX-1:0] mask, sh;
    logic                fb;
    logic [WORD_W-1:0]   prbs_w, cust_w, sq_w;
    int                  base, bidx;
    logic [7:0]          cnt;
    logic                lvl;

    always_comb begin
        st_d      = st_q;
        restart   = (kind != st_q.kind_prev) || (order != st_q.order_prev);
        eff_order = (kind == K_TRAIN2) ? ORDER_TRAIN2 : order;
        taps      = prbs_taps(eff_order);
        tap_hi    = taps[9:5];
        tap_lo    = taps[4:0];

        // PRBS: one shift per output bit, bit 0 first
        mask = '0;
        for (int k = 0; k < PRBS_MAX; k++) begin
            if (k <= int'(tap_hi)) mask[k] = 1'b1;
        end
        sh = restart ? mask : st_q.prbs;
        fb = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            fb        = sh[tap_hi] ^ sh[tap_lo];
            sh        = {sh[PRBS_MAX-2:0], fb} & mask;
            prbs_w[i] = fb;
        end
        st_d.prbs = sh;

        // user pattern: byte pointer, wraps at CUST_BYTES
        base = restart ? 0 : int'(st_q.ptr);
        bidx = 0;
        for (int j = 0; j < BPW; j++) begin
            bidx = base + j;
            if (bidx >= CUST_BYTES) bidx = bidx - CUST_BYTES;
            cust_w[8*j +: 8] = custom[8*bidx +: 8];
        end
        bidx = base + BPW;
        if (bidx >= CUST_BYTES) bidx = bidx - CUST_BYTES;
        st_d.ptr = PTR_W'(bidx);

        // square wave: level holds for sq_width bits
        cnt = restart ? 8'd0 : st_q.sq_cnt;
        lvl = restart ? 1'b1 : st_q.sq_lvl;
        for (int i = 0; i < WORD_W; i++) begin
            sq_w[i] = (sq_width != 8'd0) && lvl;
            if (sq_width != 8'd0) begin
                if (cnt >= sq_width - 8'd1) begin
                    cnt = 8'd0;
                    lvl = ~lvl;
                end else begin
                    cnt = cnt + 8'd1;
                end
            end
        end
        st_d.sq_cnt = cnt;
        st_d.sq_lvl = lvl;

        case (kind)
            K_DATA:             st_d.word = data_in;
            K_PRBS, K_TRAIN2:   st_d.word = prbs_w;
            K_CUST:             st_d.word = cust_w;
            K_SQUARE:           st_d.word = sq_w;
            K_TRAIN1:           st_d.word = TRAIN1_WORD;
            default:            st_d.word = '0;
        endcase

        st_d.kind_prev  = kind;
        st_d.order_prev = order;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_RST;
        else        st_q <= st_d;
    end

    assign word = st_q.word;

endmodule

// File: rtl/lpg_top.sv
module lpg_top
    import lpg_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int WORD_W    = 32,
    parameter int CUST_REGS = 11,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic [LANES*WORD_W-1:0]  act_data,
    output logic [LANES*WORD_W-1:0]  lane_word
);
    localparam int CUST_BYTES = CUST_REGS * 3;
    localparam int CODE_W     = $clog2(LANES);

    logic [1:0]                mode;
    logic [CODE_W-1:0]         lane_code;
    logic [LANES-1:0][2:0]     sel;
    logic [LANES-1:0][2:0]     order;
    logic [7:0]                sq_width;
    logic [CUST_BYTES*8-1:0]   custom;

    lpg_cfg #(
        .LANES(LANES), .CUST_REGS(CUST_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mode(mode), .lane_code(lane_code), .sel(sel), .order(order),
        .sq_width(sq_width), .custom(custom)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        lane_kind_e kind;

        always_comb begin
            kind = K_ZERO;
            if (ln <= int'(lane_code)) begin
                case (mode)
                    MODE_ACTIVE: kind = K_DATA;
                    MODE_TRAIN1: kind = K_TRAIN1;
                    MODE_TRAIN2: kind = K_TRAIN2;
                    default: begin
                        case (sel[ln])
                            SEL_PRBS:   kind = K_PRBS;
                            SEL_CUSTOM: kind = K_CUST;
                            SEL_SQUARE: kind = K_SQUARE;
                            SEL_TRAIN1: kind = K_TRAIN1;
                            SEL_TRAIN2: kind = K_TRAIN2;
                            default:    kind = K_ZERO;
                        endcase
                    end
                endcase
            end
        end

        lpg_lane #(
            .WORD_W(WORD_W), .CUST_BYTES(CUST_BYTES)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .kind(kind), .order(order[ln]),
            .sq_width(sq_width), .custom(custom),
            .data_in(act_data[ln*WORD_W +: WORD_W]),
            .word(lane_word[ln*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    parameter int CODE_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              mode,
    input logic [CODE_W-1:0]       lane_code,
    input logic [LANES*WORD_W-1:0] act_data,
    input logic [LANES*WORD_W-1:0] lane_word
);
    // lane 0 is always enabled; active mode forwards the sampled payload
    p_active_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (lane_word[WORD_W-1:0] == $past(act_data[WORD_W-1:0])));

    p_train1_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (lane_word[WORD_W-1:0] == {(WORD_W/2){2'b01}}));

    p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_code == '0) |=> (lane_word[LANES*WORD_W-1:WORD_W] == '0));

    if (LANES > 2) begin : g_two
        p_two_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_code == CODE_W'(1)) |=> (lane_word[LANES*WORD_W-1:2*WORD_W] == '0));
    end

endmodule

bind lpg_top lpg_checker #(
    .LANES(LANES), .WORD_W(WORD_W), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lane_code(lane_code),
    .act_data(act_data), .lane_word(lane_word)
);

// File: tb/sim_lpg_top.sv
`timescale 1ns/1ps
module sim_lpg_top;
    localparam int NL = 4;
    localparam int W  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [4:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [NL*W-1:0] act_data = '0;
    logic [NL*W-1:0] lane_word;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpg_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .act_data(act_data), .lane_word(lane_word)
    );

    // ---------------- reference model ----------------
    int m_mode, m_code, m_sqw;
    int m_sel[NL];
    int m_ord[NL];
    logic [263:0] m_cust;
    int pk[NL];
    int po[NL];
    logic [31:0] ps[NL];
    int pp[NL];
    int sc[NL];
    bit sl[NL];
    logic [31:0] expw[NL];
    string tag[NL];
    int stray = 0;
    int plen[6] = '{7, 9, 11, 15, 23, 31};
    int ptap[6] = '{6, 5, 9, 14, 18, 28};

    // kinds: 0 zero, 1 data, 2 prbs, 3 user pattern, 4 square, 5 train1, 6 train2
    function automatic int kind_of(int ln);
        if (ln > m_code) return 0;
        if (m_mode == 0) return 1;
        if (m_mode == 1) return 5;
        if (m_mode == 2) return 6;
        case (m_sel[ln])
            0: return 2;
            1: return 3;
            2: return 4;
            3: return 5;
            4: return 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (stray > 0) stray--;
        if (!rst_n) begin
            m_mode = 0; m_code = 0; m_sqw = 0; m_cust = '0;
            for (int ln = 0; ln < NL; ln++) begin
                m_sel[ln] = 0; m_ord[ln] = 0; pk[ln] = 0; po[ln] = 0;
                expw[ln] = '0; tag[ln] = "R1";
            end
        end else begin
            for (int ln = 0; ln < NL; ln++) begin
                int k, o, n, t, start, c;
                bit rs, l, b;
                logic [31:0] st, mask, pw, cw, sw;
                k  = kind_of(ln);
                rs = (k != pk[ln]) || (m_ord[ln] != po[ln]);
                o  = (k == 6) ? 2 : m_ord[ln];
                if (o > 5) o = 0;
                n = plen[o]; t = ptap[o];
                mask = (32'h1 << n) - 32'h1;
                st = rs ? mask : ps[ln];
                for (int i = 0; i < W; i++) begin
                    b = st[n-1] ^ st[t-1];
                    st = ((st << 1) | 32'(b)) & mask;
                    pw[i] = b;
                end
                ps[ln] = st;
                start = rs ? 0 : pp[ln];
                for (int i = 0; i < W; i++) cw[i] = m_cust[(start + i) % 264];
                pp[ln] = (start + W) % 264;
                c = rs ? 0 : sc[ln];
                l = rs ? 1'b1 : sl[ln];
                for (int i = 0; i < W; i++) begin
                    sw[i] = (m_sqw != 0) && l;
                    if (m_sqw != 0) begin
                        c++;
                        if (c >= m_sqw) begin c = 0; l = !l; end
                    end
                end
                sc[ln] = c; sl[ln] = l;
                case (k)
                    1: begin expw[ln] = act_data[ln*W +: W]; tag[ln] = "R2"; end
                    2: begin expw[ln] = pw; tag[ln] = (m_ord[ln] > 5) ? "R9" : "R5"; end
                    3: begin expw[ln] = cw; tag[ln] = "R6"; end
                    4: begin expw[ln] = sw; tag[ln] = "R7"; end
                    5: begin expw[ln] = 32'h5555_5555; tag[ln] = "R3"; end
                    6: begin expw[ln] = pw; tag[ln] = "R4"; end
                    default: begin
                        expw[ln] = '0;
                        tag[ln] = (ln > m_code) ? "R8" : "R9";
                    end
                endcase
                pk[ln] = k; po[ln] = m_ord[ln];
            end
            if (cfg_we) begin
                if (cfg_addr == 5'd0) begin
                    m_mode = int'(cfg_wdata[1:0]); m_code = int'(cfg_wdata[3:2]);
                end else if (cfg_addr == 5'd1) begin
                    for (int ln = 0; ln < NL; ln++) begin
                        m_sel[ln] = int'(cfg_wdata[8*ln +: 3]);
                        m_ord[ln] = int'(cfg_wdata[8*ln+4 +: 3]);
                    end
                end else if (cfg_addr == 5'd2) begin
                    m_sqw = int'(cfg_wdata[7:0]);
                end else if (cfg_addr >= 5'd16 && cfg_addr <= 5'd26) begin
                    m_cust[(int'(cfg_addr) - 16)*24 +: 24] = cfg_wdata[23:0];
                end else begin
                    stray = 4;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string rq, int ln, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s lane=%0d actual=%h expected=%h", rq, ln, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && rst_n) begin
            for (int ln = 0; ln < NL; ln++)
                chk((stray > 0) ? "R10" : tag[ln], ln,
                    128'(lane_word[ln*W +: W]), 128'(expw[ln]));
        end
    end

    always @(negedge clk) act_data <= {$urandom, $urandom, $urandom, $urandom};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        chk("R1", -1, lane_word, '0);   // R1: zero while in reset
        rst_n = 1'b1;
        started = 1'b1;
        run(6);                          // R1/R2: active mode, lane 0 only
        wr(0, 32'h0000_000C); run(6);    // R2, R8: four lanes
        wr(0, 32'h0000_0004); run(4);    // R8: two lanes
        wr(0, 32'h0000_0008); run(4);    // R8: three lanes
        wr(0, 32'h0000_000D); run(6);    // R3: training 1
        wr(0, 32'h0000_000E); run(12);   // R4: training 2
        for (int r = 0; r < 11; r++) begin
            logic [31:0] v;
            for (int b = 0; b < 3; b++) v[8*b +: 8] = 8'((3*r + b) * 37 + 11);
            v[31:24] = 8'hA5;
            wr(16 + r, v);                // R6 packing
        end
        wr(2, 32'd3);
        wr(1, 32'h5002_0100);            // R5, R6, R7, R9
        wr(0, 32'h0000_000F); run(40);
        for (int o = 1; o < 6; o++) begin
            wr(1, 32'h5002_0100 | 32'(o << 4)); run(15);   // R5 orders
        end
        wr(2, 32'd1);   run(10);         // R7 width 1
        wr(2, 32'd0);   run(5);          // R7 width 0
        wr(2, 32'd200); run(30);         // R7 long width
        wr(1, 32'h0304_7007); run(12);   // R9 invalid codes, R3, R4 selects
        wr(5, 32'hFFFF_FFFF); run(2);    // R10 stray writes
        wr(31, 32'hFFFF_FFFF); run(3);
        wr(0, 32'h0000_0003); run(5);    // R8 test mode, one lane
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule